// File: doc/BRIEF.md
# Key-Protected Random Word Generator Front End

This block is the register side of a random number peripheral. A single entropy bit enters on every clock; the block keeps the most recent 32 samples and, while generation is enabled, places them into the output word register once per fixed period. A flag in the status register tells software that a word is waiting. Reading status clears the flag. A word delivered in the same cycle as that read is never lost and never reported twice.

Software reaches the block over a plain 32-bit bus with single-cycle reads and writes. Generation is turned on or off only by a control write that carries a fixed key in its upper 24 bits, so a stray store cannot change the enable state. A mode bit selects half rate, which doubles the production period from 84 to 168 cycles.

Top module: `rng_word_front`

## Requirements
- R1: After reset the block is disabled, the mode bit is 0, the ready flag is 0 and the output word is 0. The status, mode and data registers then all read 0.
- R2: A write to the control register (offset 0x00) is accepted only when wdata bits 31:8 equal 24'h524E47. Any other control write is ignored and leaves the enable state unchanged.
- R3: In an accepted control write, wdata bit 0 = 1 enables generation and bit 0 = 0 disables it.
- R4: Status (offset 0x1C) bit 0 is the ready flag. A status read clears it on the clock edge that ends the read. If a word completes on that same edge, the flag is set, so the read returns 0 and the flag reads 1 afterwards.
- R5: The ready flag goes from 0 to 1 only on the edge where a new word completes.
- R6: With mode bit 0 cleared, the first word completes 84 clock edges after the edge that accepts the enable, and a new word completes every 84 edges after that.
- R7: The mode register (offset 0x04) bit 0 selects half rate, with one word every 168 edges. Any mode write restarts the period count, and the mode register reads back bit 0.
- R8: The output data register (offset 0x50) holds the entropy bits sampled on the last 32 rising edges, including the completing edge. The newest bit is in bit 0. The value is held until the next word completes, and reading it has no side effect.
- R9: While disabled, the period count stays at zero and no word completes. The ready flag and the last word are kept.
- R10: The control register and unmapped offsets read 0. When rd_i is low, rdata_o is 0. Read data is presented in the same cycle as rd_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (8) | Byte offset of the register accessed |
| wr_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | 32 | Read data, valid while rd_i is high |
| entropy_i | input | 1 | Entropy bit sampled on every rising edge |

## Verification
A status read can fall in the same cycle as a word completion: the read returns the old flag and the completion must win. The bench counts edges from the accepting enable or mode write. It places a status read in the last cycle of every period and expects 0. On the next cycle it expects the flag to be 1 and the data register to match a shadow shift register fed by the same pseudo-random entropy stream. Both rates are swept over many consecutive words, and wrong-key writes and disable periods are placed between them.

// File: rtl/rngw_pkg.sv
package rngw_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam logic [23:0] CTRL_KEY = 24'h524E47;
  localparam logic [7:0]  OFF_CTRL = 8'h00;
  localparam logic [7:0]  OFF_MODE = 8'h04;
  localparam logic [7:0]  OFF_STAT = 8'h1C;
  localparam logic [7:0]  OFF_DATA = 8'h50;
endpackage

// File: rtl/rngw_timer.sv
module rngw_timer #(
  parameter int unsigned NORM_PERIOD = 84,
  localparam int unsigned HALF_PERIOD = 2 * NORM_PERIOD,
  localparam int unsigned CNT_W = $clog2(HALF_PERIOD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             half_i,
  input  logic             restart_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim    = half_i ? CNT_W'(HALF_PERIOD - 1) : CNT_W'(NORM_PERIOD - 1);
  assign tick_o = en_i && (cnt_q == lim);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i || restart_i) cnt_q <= '0;
    else if (tick_o)             cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rngw_collect.sv
module rngw_collect #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  // keeps W-1 past samples; the current bit completes the word
  logic [W-2:0] hist_q;

  assign word_o = {hist_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= word_o[W-2:0];
  end
endmodule

// File: rtl/rngw_regs.sv
module rngw_regs
  import rngw_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [23:0]       key_i,
  input  logic              bit0_i,
  output logic              en_o,
  output logic              half_o,
  output logic              mode_wr_o
);
  logic ctrl_ok;

  assign ctrl_ok   = wr_i && (addr_i == ADDR_W'(OFF_CTRL)) && (key_i == CTRL_KEY);
  assign mode_wr_o = wr_i && (addr_i == ADDR_W'(OFF_MODE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      half_o <= 1'b0;
    end else begin
      if (ctrl_ok)   en_o   <= bit0_i;
      if (mode_wr_o) half_o <= bit0_i;
    end
  end
endmodule

// File: rtl/rng_word_front.sv
module rng_word_front
  import rngw_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned NORM_PERIOD = 84,
  localparam int unsigned CNT_W = $clog2(2 * NORM_PERIOD)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  input  logic              rd_i,
  output logic [31:0]       rdata_o,
  input  logic              entropy_i
);
  logic              en_q, half_q, mode_wr, tick, rdy_q;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] word, data_q;
  logic              stat_rd;
  logic              unused_wbits;

  assign unused_wbits = ^wdata_i[7:1];

  rngw_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i,
    .key_i(wdata_i[31:8]), .bit0_i(wdata_i[0]),
    .en_o(en_q), .half_o(half_q), .mode_wr_o(mode_wr)
  );

  rngw_timer #(.NORM_PERIOD(NORM_PERIOD)) u_timer (
    .clk_i, .rst_ni, .en_i(en_q), .half_i(half_q), .restart_i(mode_wr),
    .tick_o(tick), .cnt_o(cnt)
  );

  rngw_collect #(.W(DATA_W)) u_coll (
    .clk_i, .rst_ni, .bit_i(entropy_i), .word_o(word)
  );

  assign stat_rd = rd_i && (addr_i == ADDR_W'(OFF_STAT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (tick) data_q <= word;
      // completion wins over a clearing read in the same cycle
      if (tick)         rdy_q <= 1'b1;
      else if (stat_rd) rdy_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        ADDR_W'(OFF_MODE): rdata_o = {31'b0, half_q};
        ADDR_W'(OFF_STAT): rdata_o = {31'b0, rdy_q};
        ADDR_W'(OFF_DATA): rdata_o = data_q;
        default:           rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/rngw_chk.sv
module rngw_chk
  import rngw_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned HALF_PERIOD = 168
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [31:0]       wdata_i,
  input logic              rd_i,
  input logic              en_q,
  input logic              rdy_q,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt,
  input logic [31:0]       data_q
);
  AST_KEY_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(OFF_CTRL) && wdata_i[31:8] != CTRL_KEY) |=> $stable(en_q)); // R2

  AST_CLEAR_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(OFF_STAT) && !tick) |=> !rdy_q); // R4

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> rdy_q); // R4

  AST_RDY_ONLY_ON_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_q) |-> $past(tick)); // R5

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < CNT_W'(HALF_PERIOD)); // R7

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(data_q)); // R8

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> (cnt == '0)); // R9
endmodule

bind rng_word_front rngw_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .HALF_PERIOD(2 * NORM_PERIOD)
) u_chk (
  .clk_i, .rst_ni, .addr_i, .wr_i, .wdata_i, .rd_i,
  .en_q, .rdy_q, .tick, .cnt, .data_q
);

// File: tb/rng_word_front_tb.sv
module rng_word_front_tb;
  localparam logic [7:0] A_CTRL = 8'h00, A_MODE = 8'h04, A_STAT = 8'h1C, A_DATA = 8'h50;
  localparam logic [31:0] EN_ON  = 32'h524E4701;
  localparam logic [31:0] EN_OFF = 32'h524E4700;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        ent = 1'b0;
  logic [31:0] lfsr = 32'hACE1_2468;
  logic [31:0] shadow;
  int nchk = 0, nerr = 0, t = 0;
  logic [31:0] kept;

  always #4 clk = ~clk;

  rng_word_front u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rd_i(rd), .rdata_o(rdata), .entropy_i(ent)
  );

  always @(negedge clk) begin
    ent  <= lfsr[0];
    lfsr <= {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  end

  // R8 model: last 32 samples, newest in bit 0
  always @(posedge clk or negedge rst_n)
    if (!rst_n) shadow <= '0;
    else        shadow <= {shadow[30:0], ent};

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s t=%0d got %h exp %h", tag, t, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; t++;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a; rd = 1'b1;
    #1 check(rdata, exp, tag);
    @(negedge clk);
    rd = 1'b0; t++;
  endtask

  task automatic idle_to(input int target);
    while (t < target) begin
      @(negedge clk); t++;
    end
  endtask

  // status read on the completing edge, then data and flag on the next cycle
  task automatic run_words(input int n, input int p, input string tag);
    for (int k = 1; k <= n; k++) begin
      idle_to(p * k - 1);
      bus_rd(A_STAT, 32'd0, {tag, " pre"});
      bus_rd(A_DATA, shadow, {tag, " word"});
      bus_rd(A_STAT, 32'd1, {tag, " R4 set wins"});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    bus_rd(A_STAT, 32'd0, "R1 status");
    bus_rd(A_DATA, 32'd0, "R1 data");
    bus_rd(A_MODE, 32'd0, "R1 mode");
    // R10 write-only control, unmapped, idle bus
    bus_rd(A_CTRL, 32'd0, "R10 ctrl");
    bus_rd(8'h08,  32'd0, "R10 unmapped");
    addr = A_MODE; #1 check(rdata, 32'd0, "R10 rd low");
    // R2 wrong key cannot enable
    bus_wr(A_CTRL, 32'h12345601);
    repeat (200) @(negedge clk);
    bus_rd(A_STAT, 32'd0, "R2 wrong key status");
    bus_rd(A_DATA, 32'd0, "R2 wrong key data");
    // R3 R6 enable with key, normal rate
    bus_wr(A_CTRL, EN_ON); t = 0;
    run_words(12, 84, "R6");
    bus_rd(A_STAT, 32'd0, "R4 cleared");
    // R7 half rate; mode write restarts the count
    bus_wr(A_MODE, 32'h1); t = 0;
    bus_rd(A_MODE, 32'd1, "R7 mode readback");
    bus_rd(A_STAT, 32'd0, "R4 cleared before half");
    run_words(10, 168, "R7");
    // R2 wrong key while enabled: generation continues
    bus_wr(A_CTRL, 32'hAB000000);
    idle_to(168 * 11 - 1);
    bus_rd(A_STAT, 32'd0, "R2 pre");
    kept = shadow;
    bus_rd(A_DATA, kept, "R2 still enabled");
    // R3 R9 disable with flag pending
    bus_wr(A_CTRL, EN_OFF);
    repeat (400) @(negedge clk);
    bus_rd(A_DATA, kept, "R9 word kept");
    bus_rd(A_DATA, kept, "R8 data read no side effect");
    bus_rd(A_STAT, 32'd1, "R9 flag kept");
    bus_rd(A_STAT, 32'd0, "R4 clear");
    repeat (300) @(negedge clk);
    bus_rd(A_STAT, 32'd0, "R9 no new word");
    bus_rd(A_DATA, kept, "R9 data stable");
    // re-enable at normal rate
    bus_wr(A_MODE, 32'h0);
    bus_rd(A_MODE, 32'd0, "R7 mode cleared");
    bus_wr(A_CTRL, EN_ON); t = 0;
    run_words(20, 84, "R6 R8 re-enable");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule